// File: doc/BRIEF.md
# Spread Spectrum Profile Generator

This block produces the digital deviation sequence that frequency-modulates a synthesized clock for lower EMI. It takes a nominal feedback divider value and adds a triangular offset to it, one step per update tick. The result is the modulated divider value that the loop consumes. A single-bit indicator marks the rising half of the triangle.

The profile has two modes. In center mode it swings equally above and below the nominal value, so the average over each period is the nominal value. In down mode the same swing is shifted below the nominal value, so the highest point equals the nominal value. The swing amplitude comes from a 4-bit code. A rate select picks one of two modulation frequencies, and that choice sets how many ticks make up each half of the triangle. Every setting is captured only when a period ends. The waveform therefore never jumps in the middle of a period.

Top module: `ssc_profile_gen`

## Requirements
- R1: While `rstN` is low, and after its release until the first tick, modulation is inactive, `divOut` equals `divNom` and `rampUp` is 0.
- R2: While modulation is inactive, `divOut` equals the live `divNom` input in the same cycle and `rampUp` is 0.
- R3: The inputs `spreadEn`, `downMode`, `ampCode`, `rateSel` and `divNom` are captured on a tick that ends a period, or on any tick while modulation is inactive. At all other times they have no effect on `divOut` or `rampUp`.
- R4: The peak deviation is A = floor(N * (ampCode + 1) * 1311 / 2^20), where N is the captured nominal value. This gives about (ampCode + 1) * 0.125 % of N, so codes 0 to 15 span 0.125 % to 2.0 %.
- R5: Center mode (`downMode` = 0) outputs N + trunc(A * (2k - H) / H), where k is the phase and H is the half-period step count, and the division rounds toward zero. The minimum is N - A, the maximum is N + A, and the sum over one whole period equals 2H * N.
- R6: Down mode (`downMode` = 1) outputs the center-mode value minus A. The output never exceeds N, reaches N at k = H, and reaches N - 2A at k = 0.
- R7: The phase k starts each period at 0, rises by one per tick up to H, and then falls by one per tick. The tick that would bring k back to 0 ends the period, so one period lasts 2H ticks.
- R8: H = TICK_HZ / (2 * rate). With the defaults (1 MHz tick), `rateSel` = 0 selects 31.25 kHz and H = 16, and `rateSel` = 1 selects 120 kHz and H = 4.
- R9: `rampUp` is 1 while modulation is active and k is in the rising half (k = 0 to H - 1). Across the rising half `divOut` never decreases.
- R10: Without a tick, the phase, `rampUp` and the active `divOut` do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle update strobe from the reference-derived update clock |
| spreadEn | input | 1 | Modulation enable request |
| downMode | input | 1 | 0 = center spread, 1 = down spread |
| ampCode | input | AMP_W | Amplitude code |
| rateSel | input | 1 | 0 = slow rate, 1 = fast rate |
| divNom | input | DIV_W | Nominal divider value |
| divOut | output | DIV_W | Modulated divider value |
| rampUp | output | 1 | High during the rising half of the profile |

## Verification
The hardest case to reach from the ports is a settings change made in the middle of a period. The block must keep following the old triangle up to the turning point and back, and switch over only on the tick that closes the period. The stimulus starts a slow center-spread period, advances it a few ticks, and then changes every setting at once (mode, amplitude, rate and nominal value). It checks each later step against the old profile, including the old peak, and then checks that the first sample of the next period is the new down-mode minimum. Exact averaging is checked by summing every sample of a whole period and comparing the sum with 2H times the nominal value. This is also done at the smallest amplitude code, where the truncation error is largest relative to the swing.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

  // Strobes and flags passed from the control to the datapath
  typedef struct packed {
    logic load;      // capture new settings in this cycle
    logic spreadOn;  // modulation active
    logic rateFast;  // active rate is the fast one
    logic rampUp;    // rising half of the triangle
  } ssc_strobe_t;

  // Amplitude scaling: one code unit is 1/800 of the nominal value
  localparam int FRAC_BITS = 20;
  localparam int AMP_DEN   = 800;

endpackage

// File: rtl/ssc_ctrl.sv
module ssc_ctrl
  import ssc_pkg::*;
#(
  parameter int PH_W      = 5,
  parameter int HALF_SLOW = 16,
  parameter int HALF_FAST = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            tick,
  input  logic            spreadEn,
  input  logic            rateSel,
  output ssc_strobe_t     stb,
  output logic [PH_W-1:0] phase,
  output logic [PH_W-1:0] halfSteps
);

  localparam logic [PH_W-1:0] H_SLOW = PH_W'(HALF_SLOW);
  localparam logic [PH_W-1:0] H_FAST = PH_W'(HALF_FAST);
  localparam logic [PH_W-1:0] ONE    = PH_W'(1);

  logic            enQ;
  logic            rateQ;
  logic            dirUpQ;
  logic [PH_W-1:0] phaseQ;
  logic [PH_W-1:0] phaseInc;
  logic            endOfPeriod;
  logic            loadNow;

  assign halfSteps   = rateQ ? H_FAST : H_SLOW;
  assign phaseInc    = phaseQ + ONE;
  assign endOfPeriod = !dirUpQ && (phaseQ == ONE);
  assign loadNow     = tick && (!enQ || endOfPeriod);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ    <= 1'b0;
      rateQ  <= 1'b0;
      dirUpQ <= 1'b1;
      phaseQ <= '0;
    end else if (loadNow) begin
      enQ    <= spreadEn;
      rateQ  <= rateSel;
      dirUpQ <= 1'b1;
      phaseQ <= '0;
    end else if (tick) begin
      if (dirUpQ) begin
        phaseQ <= phaseInc;
        if (phaseInc == halfSteps) dirUpQ <= 1'b0;
      end else begin
        phaseQ <= phaseQ - ONE;
      end
    end
  end

  assign stb.load     = loadNow;
  assign stb.spreadOn = enQ;
  assign stb.rateFast = rateQ;
  assign stb.rampUp   = enQ && dirUpQ;
  assign phase        = phaseQ;

endmodule

// File: rtl/ssc_datapath.sv
module ssc_datapath
  import ssc_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int AMP_W     = 4,
  parameter int PH_W      = 5,
  parameter int HALF_SLOW = 16,
  parameter int HALF_FAST = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ssc_strobe_t      stb,
  input  logic [PH_W-1:0]  phase,
  input  logic [DIV_W-1:0] divNom,
  input  logic             downMode,
  input  logic [AMP_W-1:0] ampCode,
  output logic [DIV_W-1:0] divOut,
  output logic             rampUp
);

  localparam int AMP_K  = ((1 << FRAC_BITS) + AMP_DEN / 2) / AMP_DEN;
  localparam int K_W    = $clog2(AMP_K + 1);
  localparam int PROD_W = DIV_W + AMP_W + 1 + K_W;
  localparam int NUM_W  = DIV_W + PH_W + 3;

  logic [DIV_W-1:0] nomQ;
  logic [AMP_W-1:0] ampQ;
  logic             downQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nomQ  <= '0;
      ampQ  <= '0;
      downQ <= 1'b0;
    end else if (stb.load) begin
      nomQ  <= divNom;
      ampQ  <= ampCode;
      downQ <= downMode;
    end
  end

  // Peak deviation from the captured nominal value and amplitude code
  logic [PROD_W-1:0]      prod;
  logic [DIV_W-1:0]       peak;
  logic signed [NUM_W-1:0] peakS;

  assign prod  = PROD_W'(nomQ) * (PROD_W'(ampQ) + PROD_W'(1)) * PROD_W'(AMP_K);
  assign peak  = DIV_W'(prod >> FRAC_BITS);
  assign peakS = $signed(NUM_W'(peak));

  // One constant-divisor triangle evaluator per rate
  logic signed [NUM_W-1:0] devByRate [2];
  logic signed [NUM_W-1:0] phase2S;

  assign phase2S = $signed(NUM_W'({phase, 1'b0}));

  for (genvar r = 0; r < 2; r++) begin : g_rate
    localparam int HR = (r == 0) ? HALF_SLOW : HALF_FAST;
    localparam logic signed [NUM_W-1:0] HR_S = NUM_W'(HR);
    logic signed [NUM_W-1:0] spanS;
    logic signed [NUM_W-1:0] numS;
    assign spanS        = phase2S - HR_S;
    assign numS         = peakS * spanS;
    assign devByRate[r] = numS / HR_S;
  end

  logic signed [NUM_W-1:0] devS;
  logic signed [NUM_W-1:0] shiftS;
  logic signed [NUM_W-1:0] sumS;
  logic [DIV_W-1:0]        modOut;

  assign devS   = stb.rateFast ? devByRate[1] : devByRate[0];
  assign shiftS = downQ ? peakS : '0;
  assign sumS   = $signed(NUM_W'(nomQ)) - shiftS + devS;
  assign modOut = DIV_W'(sumS);

  assign divOut = stb.spreadOn ? modOut : divNom;
  assign rampUp = stb.rampUp;

endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen
  import ssc_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int AMP_W   = 4,
  parameter int TICK_HZ = 1_000_000,
  parameter int SLOW_HZ = 31_250,
  parameter int FAST_HZ = 120_000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             spreadEn,
  input  logic             downMode,
  input  logic [AMP_W-1:0] ampCode,
  input  logic             rateSel,
  input  logic [DIV_W-1:0] divNom,
  output logic [DIV_W-1:0] divOut,
  output logic             rampUp
);

  localparam int HALF_SLOW = TICK_HZ / (2 * SLOW_HZ);
  localparam int HALF_FAST = TICK_HZ / (2 * FAST_HZ);
  localparam int HALF_MAX  = (HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST;
  localparam int PH_W      = $clog2(HALF_MAX + 1);

  ssc_strobe_t     ctrlStb;
  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] halfSteps;

  ssc_ctrl #(
    .PH_W     (PH_W),
    .HALF_SLOW(HALF_SLOW),
    .HALF_FAST(HALF_FAST)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .spreadEn (spreadEn),
    .rateSel  (rateSel),
    .stb      (ctrlStb),
    .phase    (phase),
    .halfSteps(halfSteps)
  );

  ssc_datapath #(
    .DIV_W    (DIV_W),
    .AMP_W    (AMP_W),
    .PH_W     (PH_W),
    .HALF_SLOW(HALF_SLOW),
    .HALF_FAST(HALF_FAST)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (ctrlStb),
    .phase   (phase),
    .divNom  (divNom),
    .downMode(downMode),
    .ampCode (ampCode),
    .divOut  (divOut),
    .rampUp  (rampUp)
  );

endmodule

// File: rtl/ssc_profile_chk.sv
module ssc_profile_chk
  import ssc_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int PH_W  = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             tick,
  input logic [DIV_W-1:0] divNom,
  input logic [DIV_W-1:0] divOut,
  input logic             rampUp,
  input ssc_strobe_t      stb,
  input logic [PH_W-1:0]  phase,
  input logic [PH_W-1:0]  halfSteps
);

  // R7: the phase never passes the turning point
  p_phase_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    phase <= halfSteps);

  // R3: capturing new settings restarts the triangle at phase zero
  p_load_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> (phase == '0));

  // R9: the output does not fall during the rising half
  p_rise_mono_r9: assert property (@(posedge clk) disable iff (!rstN)
    (tick && rampUp) |=> (divOut >= $past(divOut)));

  // R10: without a tick the phase and indicator hold
  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> ($stable(phase) && $stable(rampUp)));

  // R2: inactive modulation passes the nominal value straight through
  p_passthru_r2: assert property (@(posedge clk) disable iff (!rstN)
    !stb.spreadOn |-> ((divOut == divNom) && !rampUp));

endmodule

bind ssc_profile_gen ssc_profile_chk #(
  .DIV_W(DIV_W),
  .PH_W (PH_W)
) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .tick     (tick),
  .divNom   (divNom),
  .divOut   (divOut),
  .rampUp   (rampUp),
  .stb      (ctrlStb),
  .phase    (phase),
  .halfSteps(halfSteps)
);

// File: tb/test_ssc_profile_gen.sv
module test_ssc_profile_gen;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN;
  logic        tick;
  logic        spreadEn;
  logic        downMode;
  logic [3:0]  ampCode;
  logic        rateSel;
  logic [15:0] divNom;
  logic [15:0] divOut;
  logic        rampUp;

  int checks = 0;
  int errors = 0;

  // Model of the captured settings and the triangle position
  bit     mEn, mRate, mDown, mUp, mLoaded;
  int     mAmp, mk;
  longint mNom;

  ssc_profile_gen i_ssc_profile_gen (
    .clk(clk), .rstN(rstN), .tick(tick), .spreadEn(spreadEn),
    .downMode(downMode), .ampCode(ampCode), .rateSel(rateSel),
    .divNom(divNom), .divOut(divOut), .rampUp(rampUp)
  );

  function automatic int halfOf(bit r);
    return r ? 4 : 16;
  endfunction

  function automatic longint peakOf(longint n, int a);
    return (n * (a + 1) * 1311) >>> 20;
  endfunction

  function automatic longint expDiv();
    longint a, h, dev;
    if (!mEn) return longint'(divNom);
    a   = peakOf(mNom, mAmp);
    h   = halfOf(mRate);
    dev = (a * (2 * mk - h)) / h;
    return mNom - (mDown ? a : 0) + dev;
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic checkState(string req);
    check(req, longint'(divOut), expDiv());
    check(req, longint'(rampUp), longint'(mEn && mUp));
  endtask

  task automatic stepModel();
    mLoaded = 1'b0;
    if (!mEn || (!mUp && mk == 1)) begin
      mEn = spreadEn; mRate = rateSel; mDown = downMode;
      mAmp = int'(ampCode); mNom = longint'(divNom);
      mk = 0; mUp = 1'b1; mLoaded = 1'b1;
    end else if (mUp) begin
      mk++;
      if (mk == halfOf(mRate)) mUp = 1'b0;
    end else begin
      mk--;
    end
  endtask

  task automatic tickOnce();
    @(negedge clk);
    tick = 1'b1;
    stepModel();
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic tickUntilLoad(string req);
    for (int i = 0; i < 64; i++) begin
      tickOnce();
      if (mLoaded) return;
      checkState(req);
    end
  endtask

  task automatic testReset();
    rstN = 1'b0; tick = 1'b0; spreadEn = 1'b0; downMode = 1'b0;
    ampCode = 4'd0; rateSel = 1'b0; divNom = 16'd1234;
    mEn = 0; mRate = 0; mDown = 0; mUp = 1; mk = 0; mAmp = 0; mNom = 0;
    repeat (3) @(negedge clk);
    check("R1 reset divOut", longint'(divOut), 1234);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset divOut", longint'(divOut), 1234);
    check("R1 after reset rampUp", longint'(rampUp), 0);
  endtask

  task automatic testPassThrough();
    divNom = 16'd777;
    #1;
    check("R2 live passthrough", longint'(divOut), 777);
    for (int i = 0; i < 3; i++) begin
      tickOnce();
      check("R2 disabled tick", longint'(divOut), 777);
      check("R2 disabled rampUp", longint'(rampUp), 0);
    end
  endtask

  task automatic testCenterSlow();
    longint sum, mx, mn;
    spreadEn = 1'b1; downMode = 1'b0; ampCode = 4'd7; rateSel = 1'b0;
    divNom = 16'd40000;
    tickOnce();
    check("R3 load while inactive", longint'(mLoaded), 1);
    check("R4 center min at k=0", longint'(divOut), 39600);
    checkState("R9 first sample");
    sum = divOut; mx = divOut; mn = divOut;
    for (int i = 1; i < 32; i++) begin
      tickOnce();
      checkState("R5 center slow profile");
      sum += divOut;
      if (divOut > mx) mx = divOut;
      if (divOut < mn) mn = divOut;
    end
    check("R5 center period sum", sum, 32 * 40000);
    check("R5 center max", mx, 40400);
    check("R5 center min", mn, 39600);
    tickOnce();
    check("R7 period of 2H ticks", longint'(mLoaded), 1);
    checkState("R7 new period start");
  endtask

  task automatic testMidChange();
    for (int i = 0; i < 5; i++) tickOnce();
    spreadEn = 1'b1; downMode = 1'b1; ampCode = 4'd15; rateSel = 1'b1;
    divNom = 16'd20000;
    for (int i = 0; i < 11; i++) begin
      tickOnce();
      checkState("R3 old profile held");
    end
    check("R3 old peak held", longint'(divOut), 40400);
    tickUntilLoad("R3 old profile held");
    check("R6 new down min", longint'(divOut), 19200);
    checkState("R3 new settings");
  endtask

  task automatic testDownFast();
    longint mx, mn;
    int highs;
    mx = divOut; mn = divOut;
    for (int p = 0; p < 3; p++) begin
      highs = 0;
      for (int i = 0; i < 8; i++) begin
        if (rampUp) highs++;
        if (i > 0 || p > 0) begin
          if (divOut > mx) mx = divOut;
          if (divOut < mn) mn = divOut;
        end
        tickOnce();
        checkState("R8 fast profile");
      end
      check("R8 rising ticks per period", highs, 4);
      check("R8 fast period length", longint'(mLoaded), 1);
    end
    check("R6 down max equals nominal", mx, 20000);
    check("R6 down min", mn, 19200);
  endtask

  task automatic testSmallCenter();
    longint sum;
    spreadEn = 1'b1; downMode = 1'b0; ampCode = 4'd0; rateSel = 1'b0;
    divNom = 16'd8000;
    tickUntilLoad("R4 small amplitude switch");
    check("R4 smallest code min", longint'(divOut), 7990);
    sum = divOut;
    for (int i = 1; i < 32; i++) begin
      tickOnce();
      checkState("R5 small amplitude profile");
      sum += divOut;
    end
    check("R5 small amplitude sum", sum, 32 * 8000);
  endtask

  task automatic testHold();
    logic [15:0] held;
    logic heldRamp;
    for (int i = 0; i < 3; i++) tickOnce();
    held = divOut; heldRamp = rampUp;
    repeat (25) @(negedge clk);
    check("R10 hold divOut", longint'(divOut), longint'(held));
    check("R10 hold rampUp", longint'(rampUp), longint'(heldRamp));
    tickOnce();
    checkState("R10 resume after hold");
  endtask

  task automatic testDisable();
    spreadEn = 1'b0;
    divNom = 16'd1111;
    tickOnce();
    checkState("R3 disable deferred");
    check("R3 spread still active", longint'(divOut != 16'd1111), 1);
    tickUntilLoad("R3 disable deferred");
    check("R2 passthrough after disable", longint'(divOut), 1111);
    divNom = 16'd2222;
    #1;
    check("R2 live value after disable", longint'(divOut), 2222);
    check("R2 rampUp low", longint'(rampUp), 0);
  endtask

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testPassThrough();
    testCenterSlow();
    testMidChange();
    testDownFast();
    testSmallCenter();
    testHold();
    testDisable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule